// File: doc/BRIEF.md
# Dual-Direction Latch/Flop Bus Transceiver

This block moves an 18-bit word between two buses, A and B, in both directions at once. Each direction has its own private storage node and three controls: a level-sensitive open control, a strobe, and a drive enable. With the open control high the node is transparent and the far-side output follows the near-side input. With it low the node holds. A high-to-low transition of the strobe while the node is closed loads the current input.

The two directions share nothing but the asynchronous active-low reset. Each direction presents a data word and a drive-enable flag rather than a tri-state pin, so a pad ring or a test harness can form the bidirectional pins. The A-to-B drive enable is active high and the B-to-A one is active low. Drive enables gate only the flag and never the stored word, so a word can be loaded while its output is not driving.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `ab_latch_open` is 1, `b_o` equals `a_i` and tracks every change of `a_i`.
- R2: While `ab_latch_open` is 0 and `ab_strobe` does not change, `b_o` keeps its value whatever `a_i` does.
- R3: While `ab_latch_open` is 0, a 1-to-0 transition of `ab_strobe` loads `a_i` into the A-to-B node. A 0-to-1 transition of the strobe loads nothing.
- R4: When `ab_latch_open` falls from 1 to 0, `b_o` keeps the last value that passed through.
- R5: A falling `ab_strobe` while `ab_latch_open` is 1 has no further effect. `b_o` keeps tracking `a_i`, and after the open control falls it holds the value present at that fall.
- R6: `b_oe` is 1 exactly when `ab_drive` is 1 (active high).
- R7: The B-to-A direction follows R1 to R5 with `b_i`, `ba_latch_open`, `ba_strobe` and `a_o`.
- R8: `a_oe` is 1 exactly when `ba_drive_n` is 0 (active low).
- R9: The drive enables never change the stored words. A word loaded while the drive enable is inactive appears unchanged once the enable becomes active.
- R10: While `rst_n` is 0, both nodes are cleared to zero at once, with no strobe needed, so `b_o` and `a_o` read 0.
- R11: The directions are independent. Strobes on both directions falling in the same instant each load their own input, and B-to-A controls never change `b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both nodes |
| a_i | input | WIDTH | Word sampled from bus A |
| ab_latch_open | input | 1 | A-to-B node transparent when 1 |
| ab_strobe | input | 1 | A-to-B load on falling edge |
| ab_drive | input | 1 | A-to-B drive enable, active high |
| b_o | output | WIDTH | Word to drive onto bus B |
| b_oe | output | 1 | Drive flag for bus B |
| b_i | input | WIDTH | Word sampled from bus B |
| ba_latch_open | input | 1 | B-to-A node transparent when 1 |
| ba_strobe | input | 1 | B-to-A load on falling edge |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |
| a_o | output | WIDTH | Word to drive onto bus A |
| a_oe | output | 1 | Drive flag for bus A |

## Verification
Two operations can land in one instant. A falling strobe can meet an open latch, and the falling strobes of both directions can coincide. The bench drops `ab_strobe` while `ab_latch_open` is high, then changes `a_i`. It judges the node by whether `b_o` still tracks `a_i` and whether, after the open control falls, `b_o` holds the word present at that fall. For the coincident case, both strobes fall in the same time step with different words on `a_i` and `b_i`, and each output must show only its own input.

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic             ab_latch_open,
  input  logic             ab_strobe,
  input  logic             ab_drive,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ba_latch_open,
  input  logic             ba_strobe,
  input  logic             ba_drive_n,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe
);

  localparam int NDIR = 2;

  logic [NDIR-1:0][WIDTH-1:0] src;
  logic [NDIR-1:0]            open_v;
  logic [NDIR-1:0]            stb_v;

  assign src    = {b_i, a_i};
  assign open_v = {ba_latch_open, ab_latch_open};
  assign stb_v  = {ba_strobe, ab_strobe};

  assign b_oe = ab_drive;
  assign a_oe = ~ba_drive_n;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] flp_q;
    logic             lat_tag;
    logic             flp_tag;
    logic [WIDTH-1:0] node;

    // Level path: copies the flop tag so a later edge write can be told apart.
    always_latch begin
      if (!rst_n) begin
        lat_q   <= '0;
        lat_tag <= 1'b0;
      end else if (open_v[g]) begin
        lat_q   <= src[g];
        lat_tag <= flp_tag;
      end
    end

    always_ff @(negedge stb_v[g] or negedge rst_n) begin
      if (!rst_n) begin
        flp_q   <= '0;
        flp_tag <= 1'b0;
      end else if (!open_v[g]) begin
        flp_q   <= src[g];
        flp_tag <= ~lat_tag;
      end
    end

    assign node = (flp_tag != lat_tag) ? flp_q : lat_q;

    if (g == 0) begin : g_ab
      assign b_o = node;
    end else begin : g_ba
      assign a_o = node;
    end
  end

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             rst_n,
  input logic [WIDTH-1:0] a_i,
  input logic             ab_latch_open,
  input logic             ab_strobe,
  input logic [WIDTH-1:0] b_o,
  input logic [WIDTH-1:0] b_i,
  input logic             ba_latch_open,
  input logic             ba_strobe,
  input logic [WIDTH-1:0] a_o
);

  logic [7:0] ab_rise_cnt;
  logic [7:0] ba_rise_cnt;
  logic       ab_armed;
  logic       ba_armed;

  always_ff @(posedge ab_latch_open or negedge rst_n)
    if (!rst_n) ab_rise_cnt <= '0;
    else        ab_rise_cnt <= ab_rise_cnt + 8'd1;

  always_ff @(posedge ba_latch_open or negedge rst_n)
    if (!rst_n) ba_rise_cnt <= '0;
    else        ba_rise_cnt <= ba_rise_cnt + 8'd1;

  always_ff @(negedge ab_strobe or negedge rst_n)
    if (!rst_n) ab_armed <= 1'b0;
    else        ab_armed <= 1'b1;

  always_ff @(negedge ba_strobe or negedge rst_n)
    if (!rst_n) ba_armed <= 1'b0;
    else        ba_armed <= 1'b1;

  AST_AB_OPEN_TRACKS: assert property (@(posedge ab_strobe) disable iff (!rst_n)
    ab_latch_open |-> b_o == a_i);  // R1

  AST_BA_OPEN_TRACKS: assert property (@(posedge ba_strobe) disable iff (!rst_n)
    ba_latch_open |-> a_o == b_i);  // R7

  AST_AB_EDGE_LOAD: assert property (@(negedge ab_strobe) disable iff (!rst_n)
    (ab_armed && !ab_latch_open && $past(!ab_latch_open) && $stable(ab_rise_cnt))
    |-> b_o == $past(a_i));  // R3

  AST_BA_EDGE_LOAD: assert property (@(negedge ba_strobe) disable iff (!rst_n)
    (ba_armed && !ba_latch_open && $past(!ba_latch_open) && $stable(ba_rise_cnt))
    |-> a_o == $past(b_i));  // R7

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_path_xcvr_tb.sv
module dual_path_xcvr_tb;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_i, b_i;
  logic         ab_latch_open, ab_strobe, ab_drive;
  logic         ba_latch_open, ba_strobe, ba_drive_n;
  logic [W-1:0] b_o, a_o;
  logic         b_oe, a_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_path_xcvr #(.WIDTH(W)) u_dut (
    .rst_n(rst_n), .a_i(a_i), .ab_latch_open(ab_latch_open),
    .ab_strobe(ab_strobe), .ab_drive(ab_drive), .b_o(b_o), .b_oe(b_oe),
    .b_i(b_i), .ba_latch_open(ba_latch_open), .ba_strobe(ba_strobe),
    .ba_drive_n(ba_drive_n), .a_o(a_o), .a_oe(a_oe)
  );

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a_i = 18'h2A5A5; b_i = 18'h15A5A;
    ab_latch_open = 1'b0; ba_latch_open = 1'b0;
    ab_strobe = 1'b1; ba_strobe = 1'b1;
    ab_drive = 1'b0; ba_drive_n = 1'b1;
    settle();
    check(b_o == '0, "R10 b_o in reset", b_o, '0);
    check(a_o == '0, "R10 a_o in reset", a_o, '0);
    rst_n = 1'b1;
    settle();
    check(b_o == '0, "R10 b_o after release", b_o, '0);
  endtask

  task automatic t_ab_open();
    ab_latch_open = 1'b1;
    a_i = 18'h00001; settle();
    check(b_o == 18'h00001, "R1 pattern 1", b_o, 18'h00001);
    a_i = 18'h3FFFF; settle();
    check(b_o == 18'h3FFFF, "R1 pattern 2", b_o, 18'h3FFFF);
    a_i = 18'h12345; settle();
    check(b_o == 18'h12345, "R1 pattern 3", b_o, 18'h12345);
  endtask

  task automatic t_ab_close_hold();
    ab_latch_open = 1'b0; settle();
    check(b_o == 18'h12345, "R4 keeps passed value", b_o, 18'h12345);
    a_i = 18'h0F0F0; settle();
    a_i = 18'h30303; settle();
    check(b_o == 18'h12345, "R2 steady strobe holds", b_o, 18'h12345);
  endtask

  task automatic t_ab_edge();
    a_i = 18'h2B2B2; settle();
    ab_strobe = 1'b0; settle();
    check(b_o == 18'h2B2B2, "R3 falling edge loads", b_o, 18'h2B2B2);
    a_i = 18'h01010; settle();
    ab_strobe = 1'b1; settle();
    check(b_o == 18'h2B2B2, "R3 rising edge no load", b_o, 18'h2B2B2);
  endtask

  task automatic t_ab_edge_while_open();
    ab_latch_open = 1'b1; a_i = 18'h11111; settle();
    ab_strobe = 1'b0; settle();
    a_i = 18'h22222; settle();
    check(b_o == 18'h22222, "R5 still tracks after edge", b_o, 18'h22222);
    ab_latch_open = 1'b0; settle();
    a_i = 18'h33333; settle();
    check(b_o == 18'h22222, "R5 holds value at close", b_o, 18'h22222);
    ab_strobe = 1'b1; settle();
  endtask

  task automatic t_enables();
    ab_drive = 1'b1; ba_drive_n = 1'b0; settle();
    check(b_oe == 1'b1, "R6 b_oe high", {17'b0, b_oe}, 18'd1);
    check(a_oe == 1'b1, "R8 a_oe on low enable", {17'b0, a_oe}, 18'd1);
    ab_drive = 1'b0; ba_drive_n = 1'b1; settle();
    check(b_oe == 1'b0, "R6 b_oe low", {17'b0, b_oe}, 18'd0);
    check(a_oe == 1'b0, "R8 a_oe off on high enable", {17'b0, a_oe}, 18'd0);
  endtask

  task automatic t_load_disabled();
    ab_drive = 1'b0;
    a_i = 18'h0ACE1; settle();
    ab_strobe = 1'b0; settle();
    ab_strobe = 1'b1; settle();
    check(b_oe == 1'b0, "R9 still not driving", {17'b0, b_oe}, 18'd0);
    ab_drive = 1'b1; settle();
    check(b_o == 18'h0ACE1, "R9 loaded while disabled", b_o, 18'h0ACE1);
    ab_drive = 1'b0; settle();
    check(b_o == 18'h0ACE1, "R9 disable keeps word", b_o, 18'h0ACE1);
  endtask

  task automatic t_ba();
    ba_latch_open = 1'b1; b_i = 18'h0BEEF; settle();
    check(a_o == 18'h0BEEF, "R7 B-to-A transparent", a_o, 18'h0BEEF);
    ba_latch_open = 1'b0; b_i = 18'h1C0DE; settle();
    check(a_o == 18'h0BEEF, "R7 B-to-A hold", a_o, 18'h0BEEF);
    ba_strobe = 1'b0; settle();
    check(a_o == 18'h1C0DE, "R7 B-to-A edge load", a_o, 18'h1C0DE);
    ba_strobe = 1'b1; settle();
  endtask

  task automatic t_simultaneous();
    a_i = 18'h3A3A3; b_i = 18'h05C5C; settle();
    ab_strobe = 1'b0; ba_strobe = 1'b0; settle();
    check(b_o == 18'h3A3A3, "R11 A-to-B own word", b_o, 18'h3A3A3);
    check(a_o == 18'h05C5C, "R11 B-to-A own word", a_o, 18'h05C5C);
    ab_strobe = 1'b1; ba_strobe = 1'b1; settle();
    ba_latch_open = 1'b1; b_i = 18'h2FFFF; settle();
    ba_latch_open = 1'b0; ba_drive_n = 1'b0; settle();
    check(b_o == 18'h3A3A3, "R11 B-to-A controls leave b_o", b_o, 18'h3A3A3);
    ba_drive_n = 1'b1;
  endtask

  task automatic t_async_clear();
    rst_n = 1'b0; settle();
    check(b_o == '0, "R10 mid-run clear b_o", b_o, '0);
    check(a_o == '0, "R10 mid-run clear a_o", a_o, '0);
    rst_n = 1'b1; settle();
  endtask

  initial begin
    t_reset();
    t_ab_open();
    t_ab_close_hold();
    t_ab_edge();
    t_ab_edge_while_open();
    t_enables();
    t_load_disabled();
    t_ba();
    t_simultaneous();
    t_async_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule